// File: doc/BRIEF.md
# Serial Command Receiver with Buffer Grant Negotiation

This unit serves one serial processor link in a switch fabric that joins several signal processors through a shared set of buffer queues. Words arrive on a three-wire serial receive path made of a bit clock, a frame sync and a data line. The first word of each frame is a command. It names the sender, the destination and how many payload words will follow. The unit takes the command, asks an external allocator for buffer space and waits for the answer. It then returns a status word to the sender on a three-wire serial transmit path.

The status word is one of three: full acceptance, a request to retry later, or the number of words that fit. After a non-zero grant, the sender opens a new frame of payload words. The unit forwards exactly the granted number of them, tagged with the destination, into the queue the allocator picked. Any surplus words in that frame are discarded. The allocator and the queues themselves sit outside this block.

Top module: `serial_cmd_rx_unit`

## Requirements
- R1: After synchronous reset, alloc_req, fifo_wr, tx_fs and tx_dat are low.
- R2: When the first word of a frame is taken in idle, alloc_req rises with alloc_cnt equal to bits 23:16 of that word and alloc_src equal to bits 31:28. Both hold steady until alloc_gnt is sampled high, and no fifo write happens while the request is open.
- R3: A receive word starts on the first rising rx_bclk edge after the one at which rx_fs is sampled high. It is 32 bits long and shifted most significant bit first.
- R4: If alloc_gnt_cnt is at least the requested count, the reply is 0x1 in bits 31:28 with all other bits zero. A reply is sent on tx_dat most significant bit first, starting on the tx_bclk period after the one in which tx_fs is high. Outputs change while tx_bclk is low.
- R5: If alloc_gnt_cnt is zero and the request is non-zero, the reply is 0x2 in bits 31:28 with other bits zero, no data is forwarded, and the unit returns to idle.
- R6: If 0 < alloc_gnt_cnt < requested count, the reply is 0x3 in bits 31:28 with the granted count in bits 7:0 and other bits zero.
- R7: After a non-zero grant, the first granted-count words of the next frame are written in order on fifo_data with fifo_sel equal to alloc_gnt_fifo and fifo_tgt equal to command bits 27:24. Later words of that frame are never written.
- R8: A frame sent while the request is open or the reply is still being sent is ignored. It neither alters the request nor produces writes.
- R9: Words that continue a frame after the unit has gone back to idle do not start a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bclk | input | 1 | Receive bit clock from the link |
| rx_fs | input | 1 | Receive frame sync |
| rx_dat | input | 1 | Receive serial data |
| tx_bclk | output | 1 | Transmit bit clock, divided from clk |
| tx_fs | output | 1 | Transmit frame sync |
| tx_dat | output | 1 | Transmit serial data |
| alloc_req | output | 1 | Buffer allocation request, held until grant |
| alloc_src | output | 4 | Sender address of the pending command |
| alloc_cnt | output | 8 | Word count asked for |
| alloc_gnt | input | 1 | One-cycle grant strobe from the allocator |
| alloc_gnt_cnt | input | 8 | Words the chosen queue can take (0 = none) |
| alloc_gnt_fifo | input | FSEL_W | Index of the chosen queue |
| fifo_wr | output | 1 | Payload write strobe |
| fifo_sel | output | FSEL_W | Queue index for the write |
| fifo_tgt | output | 4 | Destination address for the write |
| fifo_data | output | 32 | Payload word |

## Verification
A wrong parse of the command shows at once on alloc_cnt and alloc_src, a few clock cycles after the last command bit. A wrong grant decision shows up in the status word about 34 transmit bit periods later. A corrupted countdown or a missed halt of the receiver shows up as an extra, missing or misrouted fifo write during the next payload frame. Surplus and stray frames are therefore sent on purpose, and both the write count and alloc_req are watched after each of them.

// File: rtl/scru_pkg.sv
package scru_pkg;
  localparam int WORD_W = 32;
  localparam int CNT_W  = 8;
  localparam int ADDR_W = 4;

  // command word field positions
  localparam int SRC_HI = 31;
  localparam int TGT_HI = 27;
  localparam int CNT_HI = 23;

  typedef enum logic [3:0] {
    OP_OK   = 4'h1,
    OP_WAIT = 4'h2,
    OP_PART = 4'h3
  } reply_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_REPLY,
    ST_DATA
  } ctrl_state_e;

  function automatic logic [WORD_W-1:0] make_reply(input logic [CNT_W-1:0] want,
                                                   input logic [CNT_W-1:0] got);
    logic [WORD_W-1:0] w;
    w = '0;
    if (got >= want)      w[WORD_W-1 -: 4] = OP_OK;
    else if (got == '0)   w[WORD_W-1 -: 4] = OP_WAIT;
    else begin
      w[WORD_W-1 -: 4] = OP_PART;
      w[CNT_W-1:0]     = got;
    end
    return w;
  endfunction
endpackage

// File: rtl/scru_rx.sv
module scru_rx
  import scru_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bclk,
  input  logic              fs,
  input  logic              dat,
  input  logic              halt,
  output logic              word_vld,
  output logic              word_first,
  output logic [WORD_W-1:0] word_data
);
  localparam int CW = $clog2(WORD_W);

  logic [SYNC_STAGES-1:0] bclk_sr, fs_sr, dat_sr;
  logic bclk_d;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        bclk_sr <= bclk;
        fs_sr   <= fs;
        dat_sr  <= dat;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        bclk_sr <= {bclk_sr[SYNC_STAGES-2:0], bclk};
        fs_sr   <= {fs_sr[SYNC_STAGES-2:0], fs};
        dat_sr  <= {dat_sr[SYNC_STAGES-2:0], dat};
      end
    end
  endgenerate

  logic bclk_s, fs_s, dat_s, rise;
  assign bclk_s = bclk_sr[SYNC_STAGES-1];
  assign fs_s   = fs_sr[SYNC_STAGES-1];
  assign dat_s  = dat_sr[SYNC_STAGES-1];
  assign rise   = bclk_s & ~bclk_d;

  logic              active, first_pend;
  logic [CW-1:0]     cnt;
  logic [WORD_W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bclk_d     <= 1'b0;
      active     <= 1'b0;
      first_pend <= 1'b0;
      cnt        <= '0;
      sr         <= '0;
      word_vld   <= 1'b0;
      word_first <= 1'b0;
      word_data  <= '0;
    end else begin
      bclk_d   <= bclk_s;
      word_vld <= 1'b0;
      if (halt) begin
        active     <= 1'b0;
        first_pend <= 1'b0;
        cnt        <= '0;
      end else if (rise) begin
        if (fs_s) begin
          active     <= 1'b1;
          first_pend <= 1'b1;
          cnt        <= '0;
        end else if (active) begin
          sr <= {sr[WORD_W-2:0], dat_s};
          if (cnt == CW'(WORD_W-1)) begin
            word_vld   <= 1'b1;
            word_data  <= {sr[WORD_W-2:0], dat_s};
            word_first <= first_pend;
            first_pend <= 1'b0;
            cnt        <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/scru_tx.sv
module scru_tx
  import scru_pkg::*;
#(
  parameter int TX_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  output logic              bclk,
  output logic              fs,
  output logic              dat,
  output logic              done
);
  localparam int DW = $clog2(TX_DIV) + 1;
  localparam int SW = $clog2(WORD_W + 2);

  logic [DW-1:0]     div;
  logic              tick, fall;
  logic              busy;
  logic [SW-1:0]     slot;
  logic [WORD_W-1:0] sh;

  assign tick = (div == DW'(TX_DIV-1));
  assign fall = tick & bclk;

  always_ff @(posedge clk) begin
    if (rst) begin
      div  <= '0;
      bclk <= 1'b0;
      fs   <= 1'b0;
      dat  <= 1'b0;
      done <= 1'b0;
      busy <= 1'b0;
      slot <= '0;
      sh   <= '0;
    end else begin
      done <= 1'b0;
      div  <= tick ? '0 : div + 1'b1;
      if (tick) bclk <= ~bclk;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          sh   <= word;
          slot <= '0;
        end
      end else if (fall) begin
        if (slot == '0) begin
          fs   <= 1'b1;
          slot <= slot + 1'b1;
        end else if (slot <= SW'(WORD_W)) begin
          fs   <= 1'b0;
          dat  <= sh[WORD_W-1];
          sh   <= {sh[WORD_W-2:0], 1'b0};
          slot <= slot + 1'b1;
        end else begin
          dat  <= 1'b0;
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/scru_ctrl.sv
module scru_ctrl
  import scru_pkg::*;
#(
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic              word_first,
  input  logic [WORD_W-1:0] word_data,
  input  logic              alloc_gnt,
  input  logic [CNT_W-1:0]  gnt_cnt,
  input  logic [FSEL_W-1:0] gnt_fifo,
  input  logic              tx_done,
  output logic              halt,
  output logic              alloc_req,
  output logic [ADDR_W-1:0] alloc_src,
  output logic [CNT_W-1:0]  alloc_cnt,
  output logic              tx_start,
  output logic [WORD_W-1:0] tx_word,
  output logic              fifo_wr,
  output logic [FSEL_W-1:0] fifo_sel,
  output logic [ADDR_W-1:0] fifo_tgt,
  output logic [WORD_W-1:0] fifo_data
);
  ctrl_state_e      state;
  logic [CNT_W-1:0] left;

  assign halt = (state == ST_REQ) || (state == ST_REPLY);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      left      <= '0;
      alloc_req <= 1'b0;
      alloc_src <= '0;
      alloc_cnt <= '0;
      tx_start  <= 1'b0;
      tx_word   <= '0;
      fifo_wr   <= 1'b0;
      fifo_sel  <= '0;
      fifo_tgt  <= '0;
      fifo_data <= '0;
    end else begin
      tx_start <= 1'b0;
      fifo_wr  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (word_vld && word_first) begin
            alloc_src <= word_data[SRC_HI -: ADDR_W];
            fifo_tgt  <= word_data[TGT_HI -: ADDR_W];
            alloc_cnt <= word_data[CNT_HI -: CNT_W];
            alloc_req <= 1'b1;
            state     <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (alloc_gnt) begin
            alloc_req <= 1'b0;
            left      <= (gnt_cnt >= alloc_cnt) ? alloc_cnt : gnt_cnt;
            fifo_sel  <= gnt_fifo;
            tx_word   <= make_reply(alloc_cnt, gnt_cnt);
            tx_start  <= 1'b1;
            state     <= ST_REPLY;
          end
        end
        ST_REPLY: begin
          if (tx_done) state <= (left == '0) ? ST_IDLE : ST_DATA;
        end
        ST_DATA: begin
          if (word_vld) begin
            fifo_wr   <= 1'b1;
            fifo_data <= word_data;
            left      <= left - 1'b1;
            if (left == CNT_W'(1)) state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_cmd_rx_unit.sv
module serial_cmd_rx_unit
  import scru_pkg::*;
#(
  parameter int NUM_FIFOS   = 4,
  parameter int TX_DIV      = 2,
  parameter int SYNC_STAGES = 2,
  localparam int FSEL_W     = (NUM_FIFOS > 1) ? $clog2(NUM_FIFOS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_bclk,
  input  logic              rx_fs,
  input  logic              rx_dat,
  output logic              tx_bclk,
  output logic              tx_fs,
  output logic              tx_dat,
  output logic              alloc_req,
  output logic [3:0]        alloc_src,
  output logic [7:0]        alloc_cnt,
  input  logic              alloc_gnt,
  input  logic [7:0]        alloc_gnt_cnt,
  input  logic [FSEL_W-1:0] alloc_gnt_fifo,
  output logic              fifo_wr,
  output logic [FSEL_W-1:0] fifo_sel,
  output logic [3:0]        fifo_tgt,
  output logic [31:0]       fifo_data
);
  logic              w_vld, w_first, halt, tx_start, tx_done;
  logic [WORD_W-1:0] w_data, tx_word;

  scru_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst(rst), .bclk(rx_bclk), .fs(rx_fs), .dat(rx_dat),
    .halt(halt), .word_vld(w_vld), .word_first(w_first), .word_data(w_data)
  );

  scru_ctrl #(.FSEL_W(FSEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .word_vld(w_vld), .word_first(w_first),
    .word_data(w_data), .alloc_gnt(alloc_gnt), .gnt_cnt(alloc_gnt_cnt),
    .gnt_fifo(alloc_gnt_fifo), .tx_done(tx_done), .halt(halt),
    .alloc_req(alloc_req), .alloc_src(alloc_src), .alloc_cnt(alloc_cnt),
    .tx_start(tx_start), .tx_word(tx_word), .fifo_wr(fifo_wr),
    .fifo_sel(fifo_sel), .fifo_tgt(fifo_tgt), .fifo_data(fifo_data)
  );

  scru_tx #(.TX_DIV(TX_DIV)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .word(tx_word),
    .bclk(tx_bclk), .fs(tx_fs), .dat(tx_dat), .done(tx_done)
  );
endmodule

// File: rtl/scru_checker.sv
module scru_checker (
  input logic       clk,
  input logic       rst,
  input logic       alloc_req,
  input logic [7:0] alloc_cnt,
  input logic       alloc_gnt,
  input logic [7:0] alloc_gnt_cnt,
  input logic       fifo_wr,
  input logic       tx_fs
);
  logic [7:0] budget;

  always_ff @(posedge clk) begin
    if (rst) budget <= '0;
    else if (alloc_gnt && alloc_req)
      budget <= (alloc_gnt_cnt >= alloc_cnt) ? alloc_cnt : alloc_gnt_cnt;
    else if (fifo_wr && budget != 8'd0)
      budget <= budget - 8'd1;
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    alloc_req && !alloc_gnt |=> alloc_req && $stable(alloc_cnt)); // R2
  AST_NO_WR_PENDING: assert property (@(posedge clk) disable iff (rst)
    alloc_req |-> !fifo_wr); // R2
  AST_WR_BUDGET: assert property (@(posedge clk) disable iff (rst)
    fifo_wr |-> budget != 8'd0); // R7
  AST_TX_AFTER_GNT: assert property (@(posedge clk) disable iff (rst)
    alloc_req |-> !tx_fs); // R4
endmodule

bind serial_cmd_rx_unit scru_checker u_chk (
  .clk(clk), .rst(rst), .alloc_req(alloc_req), .alloc_cnt(alloc_cnt),
  .alloc_gnt(alloc_gnt), .alloc_gnt_cnt(alloc_gnt_cnt),
  .fifo_wr(fifo_wr), .tx_fs(tx_fs)
);

// File: tb/tb_serial_cmd_rx_unit.sv
`timescale 1ns/1ps
module tb_serial_cmd_rx_unit;
  localparam int HALF = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic rx_bclk = 1'b0, rx_fs = 1'b0, rx_dat = 1'b0;
  logic tx_bclk, tx_fs, tx_dat;
  logic alloc_req, alloc_gnt = 1'b0;
  logic [3:0] alloc_src, fifo_tgt;
  logic [7:0] alloc_cnt, alloc_gnt_cnt = '0;
  logic [1:0] alloc_gnt_fifo = '0, fifo_sel;
  logic fifo_wr;
  logic [31:0] fifo_data;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  serial_cmd_rx_unit dut (
    .clk(clk), .rst(rst), .rx_bclk(rx_bclk), .rx_fs(rx_fs), .rx_dat(rx_dat),
    .tx_bclk(tx_bclk), .tx_fs(tx_fs), .tx_dat(tx_dat),
    .alloc_req(alloc_req), .alloc_src(alloc_src), .alloc_cnt(alloc_cnt),
    .alloc_gnt(alloc_gnt), .alloc_gnt_cnt(alloc_gnt_cnt),
    .alloc_gnt_fifo(alloc_gnt_fifo), .fifo_wr(fifo_wr), .fifo_sel(fifo_sel),
    .fifo_tgt(fifo_tgt), .fifo_data(fifo_data)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_reply(input logic [7:0] want, input logic [7:0] got);
    if (got >= want) return 32'h1000_0000;
    if (got == 8'd0) return 32'h2000_0000;
    return {4'h3, 20'h0, got};
  endfunction

  // reply decoder and write recorder
  logic [31:0] rep_sr, rep_last;
  int rep_n = 0, rep_bits = -1;
  logic tx_bclk_q = 1'b0;
  logic [31:0] wr_data [0:63];
  logic [1:0]  wr_sel  [0:63];
  logic [3:0]  wr_tgt  [0:63];
  int wr_n = 0;

  always @(negedge clk) begin
    if (!rst && tx_bclk && !tx_bclk_q) begin
      if (rep_bits < 0) begin
        if (tx_fs) rep_bits = 0;
      end else begin
        rep_sr = {rep_sr[30:0], tx_dat};
        rep_bits++;
        if (rep_bits == 32) begin
          rep_last = rep_sr;
          rep_n++;
          rep_bits = -1;
        end
      end
    end
    tx_bclk_q = tx_bclk;
    if (!rst && fifo_wr && wr_n < 64) begin
      wr_data[wr_n] = fifo_data;
      wr_sel[wr_n]  = fifo_sel;
      wr_tgt[wr_n]  = fifo_tgt;
      wr_n++;
    end
  end

  // serial driver
  logic [31:0] fw [0:15];

  task automatic slot(input logic f, input logic d);
    @(negedge clk);
    rx_bclk = 1'b0; rx_fs = f; rx_dat = d;
    repeat (HALF) @(negedge clk);
    rx_bclk = 1'b1;
    repeat (HALF - 1) @(negedge clk);
  endtask

  task automatic send_frame(input int n);
    slot(1'b1, 1'b0);
    for (int w = 0; w < n; w++)
      for (int b = 31; b >= 0; b--) slot(1'b0, fw[w][b]);
    slot(1'b0, 1'b0);
    slot(1'b0, 1'b0);
  endtask

  task automatic wait_req(output bit ok);
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (alloc_req) begin ok = 1; break; end
    end
  endtask

  task automatic run_txn(input logic [3:0] src, input logic [3:0] tgt, input logic [7:0] cnt,
                         input logic [7:0] gnt, input logic [1:0] fsel, input int extra,
                         input bit stray);
    bit ok;
    int base, rbase, granted;
    logic [31:0] data [0:15];
    granted = (gnt >= cnt) ? int'(cnt) : int'(gnt);
    fw[0] = {src, tgt, cnt, 4'h5, 12'h0};
    send_frame(1);
    wait_req(ok);
    check("R2 request raised", {31'b0, ok}, 32'd1);
    check("R2 count field", {24'b0, alloc_cnt}, {24'b0, cnt});
    check("R3 source field MSB first", {28'b0, alloc_src}, {28'b0, src});
    base = wr_n;
    if (stray) begin
      fw[0] = 32'hFFFF_FFFF; fw[1] = 32'h0123_4567;
      send_frame(2);
      check("R8 request kept", {23'b0, alloc_req, alloc_cnt}, {23'b0, 1'b1, cnt});
      check("R8 no writes", wr_n, base);
    end
    repeat (5) @(negedge clk);
    check("R2 held until grant", {31'b0, alloc_req}, 32'd1);
    rbase = rep_n;
    alloc_gnt = 1'b1; alloc_gnt_cnt = gnt; alloc_gnt_fifo = fsel;
    @(negedge clk);
    alloc_gnt = 1'b0;
    for (int i = 0; i < 3000 && rep_n == rbase; i++) @(negedge clk);
    if (gnt >= cnt)       check("R4 OK reply", rep_last, exp_reply(cnt, gnt));
    else if (gnt == 8'd0) check("R5 WAIT reply", rep_last, exp_reply(cnt, gnt));
    else                  check("R6 count reply", rep_last, exp_reply(cnt, gnt));
    check("R4 one reply", rep_n, rbase + 1);
    repeat (20) @(negedge clk);
    if (granted > 0) begin
      for (int i = 0; i < granted + extra; i++) begin
        data[i] = $urandom;
        fw[i] = data[i];
      end
      send_frame(granted + extra);
      repeat (10) @(negedge clk);
      check("R7 write count", wr_n - base, granted);
      for (int i = 0; i < granted; i++) begin
        check("R7 data", wr_data[base + i], data[i]);
        check("R7 route", {26'b0, wr_sel[base + i], wr_tgt[base + i]}, {26'b0, fsel, tgt});
      end
      check("R9 no new request", {31'b0, alloc_req}, 32'd0);
    end else begin
      check("R5 no writes", wr_n - base, 0);
      check("R5 back to idle", {31'b0, alloc_req}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-chain: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset outputs", {28'b0, alloc_req, fifo_wr, tx_fs, tx_dat}, 32'd0);
    run_txn(4'h2, 4'h7, 8'd5, 8'd5, 2'd1, 2, 1'b0); // full grant, surplus dropped
    run_txn(4'h9, 4'h3, 8'd6, 8'd0, 2'd0, 0, 1'b0); // no space
    run_txn(4'hA, 4'hC, 8'd8, 8'd3, 2'd2, 3, 1'b1); // partial, stray frame
    run_txn(4'h1, 4'h4, 8'd0, 8'd0, 2'd3, 0, 1'b0); // zero-count request
    run_txn(4'hF, 4'h0, 8'd3, 8'd9, 2'd3, 0, 1'b1); // excess grant
    for (int t = 0; t < 14; t++) begin
      logic [7:0] c, g;
      c = 8'(1 + $urandom_range(0, 11));
      g = 8'($urandom_range(0, int'(c) + 3));
      run_txn(4'($urandom), 4'($urandom), c, g, 2'($urandom), $urandom_range(0, 2),
              1'($urandom_range(0, 1)));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule